// File: doc/BRIEF.md
# Addressed Multidrop Serial Receiver

This block is the receiving end of a one-way serial bus. One transmitter shares a single wire with up to four receivers. Every frame carries a two-bit destination field ahead of an eight-bit payload. The receiver oversamples the line with a tick that runs at sixteen times the bit rate, finds each start bit and samples every following bit at its centre. It rebuilds the ten information bits and then checks the stop bit.

A frame whose destination equals the receiver's strapped node address is accepted. Its payload is compared with a fixed expected byte, and the result drives a registered match output. That output holds its value until the next accepted frame arrives. Frames sent to the other three nodes are dropped without any visible effect. A low stop bit produces a one-cycle framing-error pulse and leaves the match output untouched. The receiver then waits for the line to go high again before it looks for the next start bit.

The block is meant for a 10 MHz clock. With the defaults, the tick divider gives a tick every 5 clocks, which is 125 kbit/s. Reset is synchronous and active high.

Top module: `mdrx_top`

## Requirements
- R1: A frame is the idle-high line going low for one start bit, then two address bits sent most significant first, then eight payload bits sent least significant first, then one high stop bit. Each bit lasts OSR (16) ticks, and a tick occurs once every TICK_DIV clocks.
- R2: When a frame is accepted, match_o becomes 1 if its payload equals EXPECT (8'hBB) and 0 for any other payload, including the bit-reversed value 8'hDD.
- R3: A frame whose address differs from node_addr leaves match_o unchanged and produces no frame_err_o pulse.
- R4: Each of the four values of node_addr selects that node. A receiver strapped to any address accepts frames sent to that address.
- R5: A low level that ends before the middle of the start bit is rejected as a glitch. It changes no output, and the next frame is received normally.
- R6: A frame whose stop bit is sampled low raises frame_err_o for exactly one clock and leaves match_o unchanged.
- R7: After a framing error, a line that stays low for further bit periods does not start a new frame. Reception resumes once the line has returned high.
- R8: match_o keeps its value in every cycle between accepted frames.
- R9: A synchronous active-high reset clears match_o and frame_err_o and abandons any frame in progress. The next complete frame is then received normally.
- R10: The match_o update and the frame_err_o pulse for a frame both appear before the end of that frame's stop-bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (10 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | ADDR_W | Strapped address of this receiver |
| rx_line | input | 1 | Serial bus line, idle high |
| match_o | output | 1 | Registered result of the payload comparison for the last accepted frame |
| frame_err_o | output | 1 | One-clock pulse when a stop bit is sampled low |

## Verification
Each result has a known deadline. A frame's decision is taken at the middle of its stop bit and registered once more, so both the new match_o value and any frame_err_o pulse must be present before the stop-bit period ends. The bench therefore treats the interval from the start edge to the end of the stop bit as an open window. In that window, match_o may only hold either its previous value or the value the model predicts, and framing-error pulses are counted. From the end of the stop bit onward, both outputs are compared exactly on every clock. Glitches and reset are handled the same way: outputs are checked in the same cycle-by-cycle manner once the line has been back high for a full bit.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,   // waiting for a falling edge
    ST_START,  // confirming the start bit at mid-bit
    ST_BITS,   // shifting in address and payload
    ST_STOP,   // sampling the stop bit
    ST_BREAK   // line held low after framing error
  } rx_state_e;

endpackage

// File: rtl/mdrx_tick.sv
module mdrx_tick #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/mdrx_sync.sv
module mdrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr;

  // Reset to all ones so the line reads as idle.
  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];

endmodule

// File: rtl/mdrx_deframe.sv
module mdrx_deframe
  import mdrx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  output logic              fr_valid,
  output logic              fr_err,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int NBITS = ADDR_W + DATA_W;
  localparam int OW    = $clog2(OSR);
  localparam int BW    = $clog2(NBITS);

  rx_state_e   state;
  logic [OW-1:0] os_cnt;
  logic [BW-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      os_cnt   <= '0;
      bit_idx  <= '0;
      addr_o   <= '0;
      data_o   <= '0;
      fr_valid <= 1'b0;
      fr_err   <= 1'b0;
    end else begin
      fr_valid <= 1'b0;
      fr_err   <= 1'b0;
      if (tick) begin
        case (state)
          ST_HUNT: begin
            os_cnt <= '0;
            if (!rxd) state <= ST_START;
          end
          ST_START: begin
            if (os_cnt == OW'(OSR / 2 - 1)) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              state   <= rxd ? ST_HUNT : ST_BITS;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_BITS: begin
            if (os_cnt == OW'(OSR - 1)) begin
              os_cnt <= '0;
              if (bit_idx < BW'(ADDR_W))
                addr_o <= ADDR_W'({addr_o, rxd});          // address: MSB first
              else
                data_o <= {rxd, data_o[DATA_W-1:1]};       // payload: LSB first
              if (bit_idx == BW'(NBITS - 1)) state <= ST_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (os_cnt == OW'(OSR - 1)) begin
              os_cnt <= '0;
              if (rxd) begin
                fr_valid <= 1'b1;
                state    <= ST_HUNT;
              end else begin
                fr_err <= 1'b1;
                state  <= ST_BREAK;
              end
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_BREAK: begin
            if (rxd) state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdrx_top.sv
module mdrx_top #(
  parameter int                 TICK_DIV    = 5,
  parameter int                 OSR         = 16,
  parameter int                 ADDR_W      = 2,
  parameter int                 DATA_W      = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0]  EXPECT      = 8'hBB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              rx_line,
  output logic              match_o,
  output logic              frame_err_o
);

  logic              tick;
  logic              rxd;
  logic              fr_valid;
  logic              fr_err;
  logic [ADDR_W-1:0] fr_addr;
  logic [DATA_W-1:0] fr_data;

  mdrx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  mdrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rx_line),
    .q_o (rxd)
  );

  mdrx_deframe #(.OSR(OSR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deframe (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rxd      (rxd),
    .fr_valid (fr_valid),
    .fr_err   (fr_err),
    .addr_o   (fr_addr),
    .data_o   (fr_data)
  );

  // Address filter and payload compare, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      match_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= fr_err;
      if (fr_valid && (fr_addr == node_addr))
        match_o <= (fr_data == EXPECT);
    end
  end

endmodule

// File: rtl/mdrx_chk.sv
module mdrx_chk #(
  parameter int                ADDR_W = 2,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] EXPECT = 8'hBB
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] node_addr,
  input logic              fr_valid,
  input logic              fr_err,
  input logic [ADDR_W-1:0] fr_addr,
  input logic [DATA_W-1:0] fr_data,
  input logic              match_o,
  input logic              frame_err_o
);

  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && fr_addr == node_addr) |=> (match_o == ($past(fr_data) == EXPECT))); // R2

  AST_OTHER_NODE: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && fr_addr != node_addr) |=> $stable(match_o)); // R3

  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(fr_valid && fr_addr == node_addr) |=> $stable(match_o)); // R8

  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    fr_err |=> (frame_err_o && $stable(match_o))); // R6

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!match_o && !frame_err_o)); // R9

endmodule

bind mdrx_top mdrx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXPECT(EXPECT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .node_addr   (node_addr),
  .fr_valid    (fr_valid),
  .fr_err      (fr_err),
  .fr_addr     (fr_addr),
  .fr_data     (fr_data),
  .match_o     (match_o),
  .frame_err_o (frame_err_o)
);

// File: tb/test_mdrx_top.sv
`timescale 1ns/1ps
module test_mdrx_top;

  localparam int TDIV   = 2;
  localparam int BITCLK = TDIV * 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] node = 2'd1;
  logic       line = 1'b1;
  logic       match_o;
  logic       frame_err_o;

  int    errors = 0;
  int    checks = 0;
  int    ferr_seen = 0;
  bit    chk_en = 1'b0;
  bit    in_frame = 1'b0;
  bit    exp_match = 1'b0;
  bit    cand = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mdrx_top #(.TICK_DIV(TDIV)) i_mdrx_top (
    .clk         (clk),
    .rst         (rst),
    .node_addr   (node),
    .rx_line     (line),
    .match_o     (match_o),
    .frame_err_o (frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the behavioural model.
  always @(posedge clk) begin
    #1;
    if (chk_en) begin
      if (frame_err_o) ferr_seen++;
      if (in_frame) begin
        chk(match_o == exp_match || match_o == cand, {"R8/", cur_req}, match_o, cand);
      end else begin
        chk(match_o == exp_match, {"R10/", cur_req}, match_o, exp_match);
        chk(!frame_err_o, "R6 idle", frame_err_o, 0);
      end
    end
  end

  task automatic drive(input bit b, input int n);
    line = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] a, input logic [7:0] d,
                            input bit stop_ok, input int extra_low, input string req);
    bit nv;
    nv = exp_match;
    if (stop_ok && a == node) nv = (d == 8'hBB);
    cur_req = req;
    cand = nv;
    ferr_seen = 0;
    in_frame = 1'b1;
    drive(1'b0, BITCLK);
    for (int i = 1; i >= 0; i--) drive(a[i], BITCLK);
    for (int i = 0; i < 8; i++) drive(d[i], BITCLK);
    drive(stop_ok, BITCLK * (stop_ok ? 1 : 1 + extra_low));
    exp_match = nv;
    in_frame = 1'b0;
    chk(ferr_seen == (stop_ok ? 0 : 1), {"R6/", req}, ferr_seen, stop_ok ? 0 : 1);
    drive(1'b1, BITCLK);
  endtask

  task automatic glitch(input int n);
    cur_req = "R5";
    cand = exp_match;
    ferr_seen = 0;
    in_frame = 1'b1;
    drive(1'b0, n);
    drive(1'b1, BITCLK * 2);
    in_frame = 1'b0;
    chk(ferr_seen == 0, "R5", ferr_seen, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(match_o == 1'b0, "R9 reset", match_o, 0);
    chk(frame_err_o == 1'b0, "R9 reset", frame_err_o, 0);
    rst = 1'b0;
    chk_en = 1'b1;
    repeat (BITCLK) @(negedge clk);

    send_frame(2'd1, 8'hBB, 1, 0, "R1 match");
    send_frame(2'd1, 8'h3C, 1, 0, "R2 mismatch");
    send_frame(2'd1, 8'hBB, 1, 0, "R2 match");
    send_frame(2'd2, 8'h00, 1, 0, "R3 other node");
    send_frame(2'd0, 8'h3C, 1, 0, "R3 other node");
    send_frame(2'd3, 8'h3C, 1, 0, "R3 other node");
    send_frame(2'd1, 8'hDD, 1, 0, "R2 reversed byte");
    send_frame(2'd2, 8'hBB, 1, 0, "R3 other node");
    send_frame(2'd1, 8'hBA, 1, 0, "R2 near miss");
    glitch(6);
    send_frame(2'd1, 8'hBB, 1, 0, "R5 after glitch");
    glitch(12);
    send_frame(2'd1, 8'h00, 0, 0, "R6 bad stop");
    send_frame(2'd1, 8'h3C, 1, 0, "R7 recovery");
    send_frame(2'd1, 8'hBB, 0, 3, "R7 long break");
    send_frame(2'd1, 8'hBB, 1, 0, "R7 after break");

    for (int a = 0; a < 4; a++) begin
      node = 2'(a);
      send_frame(2'(a), 8'h11, 1, 0, "R4 node");
      send_frame(2'(a), 8'hBB, 1, 0, "R4 node");
      send_frame(2'(a + 1), 8'h11, 1, 0, "R4 filter");
    end

    // Reset in the middle of a frame.
    chk_en = 1'b0;
    drive(1'b0, BITCLK);
    drive(1'b1, BITCLK);
    drive(1'b0, BITCLK * 2);
    line = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_match = 1'b0;
    chk(match_o == 1'b0, "R9 mid-frame", match_o, 0);
    chk(frame_err_o == 1'b0, "R9 mid-frame", frame_err_o, 0);
    chk_en = 1'b1;
    repeat (BITCLK) @(negedge clk);
    send_frame(node, 8'hBB, 1, 0, "R9 after reset");

    finish_run();
  end

endmodule